// File: doc/BRIEF.md
# Bunch-Train Sample Pipeline Controller

This block decides which bunches of a pulsed accelerator train get a slot in a fixed-size sample memory, and when those samples leave. Before each train, a fill mask is shifted in one bit per cycle. Each mask bit allows or blocks storage for one bunch position. Once the mask is complete the block is armed. A train-start strobe then opens capture, and every bunch strobe that follows advances a bunch index. For each allowed bunch, the block writes the current sample and its bunch index to the next free memory address, until every slot is taken.

When the train ends, either by an explicit end strobe or at the final bunch position, the block drains the memory in write order over a valid/ready stream. Each beat carries the sample, its 12-bit bunch tag and an end marker on the final beat. The stream obeys back-pressure. While `out_valid` is high and `out_ready` is low, the beat stays on the port unchanged. A beat transfers on every cycle where both signals are high. The mask input also uses valid/ready: `pat_ready` is high only while the block is waiting for a mask or loading one.

Train starts that arrive when the block is not armed are counted as missed trains. The memory is external. It has a registered write port and a read port with one cycle of latency.

Top module: `train_sample_sequencer`

## Requirements
- R1: After reset the block waits for a mask: `pat_ready`=1, `armed`=0, `out_valid`=0, `mem_we`=0, `mem_re`=0, `overflow`=0, `missed_trains`=0.
- R2: Mask bits are accepted on cycles where `pat_valid` and `pat_ready` are both high, most significant first. The k-th accepted bit (k counted from 0) controls bunch index NUM_BUNCHES-1-k, and 1 means store. After NUM_BUNCHES accepted bits, `armed`=1 and `pat_ready`=0.
- R3: A `train_start` pulse while armed starts capture and drops `armed`. The `bunch_stb` pulses on later cycles are numbered 0, 1, 2, ... within that train.
- R4: On the cycle after a `bunch_stb` for an allowed bunch, when fewer than NUM_SLOTS samples are stored, `mem_we`=1 for exactly one cycle. `mem_waddr` equals the number of samples already stored in the train. `mem_wdata` is {bunch index (IDX_W bits, upper), `sample_in` (SAMPLE_W bits, lower)}. Blocked bunches cause no write.
- R5: An allowed bunch that arrives when all NUM_SLOTS slots are full is dropped without a write and sets `overflow`. `overflow` stays set until the next accepted train start clears it.
- R6: Capture ends on `train_end`, or after the bunch with index NUM_BUNCHES-1. Bunch strobes after that cause no write.
- R7: After capture, the stored entries appear on the stream in write order. `out_last` is high only on the final entry. With zero entries, no beat appears. After draining, the block returns to waiting for a mask (`pat_ready`=1).
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid` stays high and `out_sample`, `out_bunch` and `out_last` hold their values.
- R9: A `train_start` that arrives while the block is waiting for a mask, loading one, or draining has no other effect. It increments `missed_trains`, which saturates at its maximum. A `train_start` during capture is ignored and not counted.
- R10: `mem_re` and `mem_we` are never high in the same cycle. Reads begin only after the final write of the train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_valid | input | 1 | Mask bit offered |
| pat_ready | output | 1 | Mask bit can be accepted |
| pat_bit | input | 1 | Mask bit value, 1 = store bunch |
| train_start | input | 1 | One-cycle train start strobe |
| train_end | input | 1 | One-cycle train end strobe |
| bunch_stb | input | 1 | One-cycle strobe per bunch |
| sample_in | input | SAMPLE_W | Sample taken with the bunch strobe |
| armed | output | 1 | Mask loaded, waiting for a train |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | clog2(NUM_SLOTS) | Memory write address |
| mem_wdata | output | IDX_W+SAMPLE_W | {bunch index, sample} |
| mem_re | output | 1 | Memory read enable |
| mem_raddr | output | clog2(NUM_SLOTS) | Memory read address |
| mem_rdata | input | IDX_W+SAMPLE_W | Read data, one cycle after `mem_re` |
| out_valid | output | 1 | Stream beat valid |
| out_ready | input | 1 | Stream sink ready |
| out_sample | output | SAMPLE_W | Stored sample |
| out_bunch | output | IDX_W | Bunch index of the sample |
| out_last | output | 1 | Final beat of the train |
| overflow | output | 1 | An allowed bunch was dropped this train |
| missed_trains | output | MISS_W | Saturating count of unserved train starts |

## Verification
The bench builds the block with 40 bunch positions, 8 memory slots and a 3-bit missed-train counter. These values let a full-ones mask run past capacity in a few dozen cycles. They also bring the final bunch position within a short run, and let the missed-train counter reach saturation after a handful of stray starts. A behavioural model compares write-port contents, flags and the drained stream on every clock, with back-pressure applied on part of the readout.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LOAD    = 3'd1,
    ST_ARMED   = 3'd2,
    ST_CAPTURE = 3'd3,
    ST_READOUT = 3'd4
  } tss_state_e;
endpackage

// File: rtl/fill_mask_reg.sv
// Serial fill mask: shifts in bits, reports when a full mask is held,
// and returns the bit for a selected bunch position.
module fill_mask_reg #(
  parameter int NUM_BUNCHES = 3000,
  localparam int BW = $clog2(NUM_BUNCHES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          bit_in,
  input  logic [BW-1:0] sel_idx,
  output logic          sel_bit,
  output logic          load_done
);
  logic [NUM_BUNCHES-1:0] mask_q;
  logic [BW-1:0]          cnt_q;

  assign load_done = shift_en && (cnt_q == BW'(NUM_BUNCHES - 1));
  assign sel_bit   = mask_q[sel_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      cnt_q  <= '0;
    end else if (shift_en) begin
      mask_q <= {mask_q[NUM_BUNCHES-2:0], bit_in};
      cnt_q  <= load_done ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/capture_writer.sv
// Numbers bunches during a train, writes allowed ones to memory in order,
// and flags drops once the memory is full.
module capture_writer #(
  parameter int NUM_BUNCHES = 3000,
  parameter int NUM_SLOTS   = 512,
  parameter int SAMPLE_W    = 16,
  parameter int IDX_W       = 12,
  localparam int BW = $clog2(NUM_BUNCHES),
  localparam int AW = $clog2(NUM_SLOTS),
  localparam int CW = $clog2(NUM_SLOTS + 1),
  localparam int MW = IDX_W + SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                bunch_fire,
  input  logic                slot_enabled,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic [BW-1:0]       bunch_idx,
  output logic                last_bunch,
  output logic [CW-1:0]       stored,
  output logic                overflow,
  output logic                mem_we,
  output logic [AW-1:0]       mem_waddr,
  output logic [MW-1:0]       mem_wdata
);
  logic [BW-1:0] idx_q;
  logic [CW-1:0] stored_q;
  logic          ovf_q;
  logic          we_q;
  logic [AW-1:0] waddr_q;
  logic [MW-1:0] wdata_q;
  logic          full;
  logic          store;

  assign full       = (stored_q == CW'(NUM_SLOTS));
  assign store      = bunch_fire && slot_enabled && !full;
  assign last_bunch = (idx_q == BW'(NUM_BUNCHES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      stored_q <= '0;
      ovf_q    <= 1'b0;
      we_q     <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      we_q <= store;
      if (store) begin
        waddr_q <= stored_q[AW-1:0];
        wdata_q <= {IDX_W'(idx_q), sample_in};
      end
      if (clear) begin
        idx_q    <= '0;
        stored_q <= '0;
        ovf_q    <= 1'b0;
      end else if (bunch_fire) begin
        if (!last_bunch) idx_q <= idx_q + 1'b1;
        if (store) stored_q <= stored_q + 1'b1;
        if (slot_enabled && full) ovf_q <= 1'b1;
      end
    end
  end

  assign bunch_idx = idx_q;
  assign stored    = stored_q;
  assign overflow  = ovf_q;
  assign mem_we    = we_q;
  assign mem_waddr = waddr_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/readout_engine.sv
// Drains stored entries from the one-cycle-latency memory into a
// valid/ready stream with an output holding register.
module readout_engine #(
  parameter int NUM_SLOTS = 512,
  parameter int SAMPLE_W  = 16,
  parameter int IDX_W     = 12,
  localparam int AW = $clog2(NUM_SLOTS),
  localparam int CW = $clog2(NUM_SLOTS + 1),
  localparam int MW = IDX_W + SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                active,
  input  logic                write_busy,
  input  logic [CW-1:0]       stored,
  output logic                mem_re,
  output logic [AW-1:0]       mem_raddr,
  input  logic [MW-1:0]       mem_rdata,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic [IDX_W-1:0]    out_bunch,
  output logic                out_last,
  output logic                drained
);
  logic [CW-1:0]       rd_ptr_q;
  logic                pend_q;
  logic                ov_q;
  logic [SAMPLE_W-1:0] smp_q;
  logic [IDX_W-1:0]    tag_q;
  logic                last_q;
  logic                issue;

  assign issue     = active && !pend_q && !ov_q && !write_busy && (rd_ptr_q != stored);
  assign mem_re    = issue;
  assign mem_raddr = rd_ptr_q[AW-1:0];
  assign drained   = (rd_ptr_q == stored) && !pend_q && !ov_q && !write_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      pend_q   <= 1'b0;
      ov_q     <= 1'b0;
      smp_q    <= '0;
      tag_q    <= '0;
      last_q   <= 1'b0;
    end else begin
      if (clear)      rd_ptr_q <= '0;
      else if (issue) rd_ptr_q <= rd_ptr_q + 1'b1;
      pend_q <= issue;
      if (pend_q) begin
        ov_q   <= 1'b1;
        smp_q  <= mem_rdata[SAMPLE_W-1:0];
        tag_q  <= mem_rdata[MW-1:SAMPLE_W];
        last_q <= (rd_ptr_q == stored);
      end else if (ov_q && out_ready) begin
        ov_q <= 1'b0;
      end
    end
  end

  assign out_valid  = ov_q;
  assign out_sample = smp_q;
  assign out_bunch  = tag_q;
  assign out_last   = last_q;
endmodule

// File: rtl/train_sample_sequencer.sv
module train_sample_sequencer
  import tss_pkg::*;
#(
  parameter int NUM_BUNCHES = 3000,
  parameter int NUM_SLOTS   = 512,
  parameter int SAMPLE_W    = 16,
  parameter int IDX_W       = 12,
  parameter int MISS_W      = 8,
  localparam int BW = $clog2(NUM_BUNCHES),
  localparam int AW = $clog2(NUM_SLOTS),
  localparam int CW = $clog2(NUM_SLOTS + 1),
  localparam int MW = IDX_W + SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pat_valid,
  output logic                pat_ready,
  input  logic                pat_bit,
  input  logic                train_start,
  input  logic                train_end,
  input  logic                bunch_stb,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic                armed,
  output logic                mem_we,
  output logic [AW-1:0]       mem_waddr,
  output logic [MW-1:0]       mem_wdata,
  output logic                mem_re,
  output logic [AW-1:0]       mem_raddr,
  input  logic [MW-1:0]       mem_rdata,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic [IDX_W-1:0]    out_bunch,
  output logic                out_last,
  output logic                overflow,
  output logic [MISS_W-1:0]   missed_trains
);
  tss_state_e    state_q, state_d;
  logic          pat_fire, load_done, sel_bit;
  logic          start_ok, bunch_fire, capture_end, miss_evt, drained;
  logic [BW-1:0] bunch_idx;
  logic          last_bunch;
  logic [CW-1:0] stored;
  logic [MISS_W-1:0] missed_q;

  assign pat_ready   = (state_q == ST_IDLE) || (state_q == ST_LOAD);
  assign pat_fire    = pat_valid && pat_ready;
  assign armed       = (state_q == ST_ARMED);
  assign start_ok    = armed && train_start;
  assign bunch_fire  = (state_q == ST_CAPTURE) && bunch_stb;
  assign capture_end = (state_q == ST_CAPTURE) && (train_end || (bunch_stb && last_bunch));
  assign miss_evt    = train_start && (pat_ready || (state_q == ST_READOUT));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (pat_fire) state_d = load_done ? ST_ARMED : ST_LOAD;
      ST_LOAD:    if (load_done) state_d = ST_ARMED;
      ST_ARMED:   if (train_start) state_d = ST_CAPTURE;
      ST_CAPTURE: if (capture_end) state_d = ST_READOUT;
      ST_READOUT: if (drained) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      missed_q <= '0;
    end else begin
      state_q <= state_d;
      if (miss_evt && (missed_q != {MISS_W{1'b1}})) missed_q <= missed_q + 1'b1;
    end
  end

  assign missed_trains = missed_q;

  fill_mask_reg #(.NUM_BUNCHES(NUM_BUNCHES)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (pat_fire),
    .bit_in    (pat_bit),
    .sel_idx   (bunch_idx),
    .sel_bit   (sel_bit),
    .load_done (load_done)
  );

  capture_writer #(
    .NUM_BUNCHES (NUM_BUNCHES),
    .NUM_SLOTS   (NUM_SLOTS),
    .SAMPLE_W    (SAMPLE_W),
    .IDX_W       (IDX_W)
  ) u_wr (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (start_ok),
    .bunch_fire   (bunch_fire),
    .slot_enabled (sel_bit),
    .sample_in    (sample_in),
    .bunch_idx    (bunch_idx),
    .last_bunch   (last_bunch),
    .stored       (stored),
    .overflow     (overflow),
    .mem_we       (mem_we),
    .mem_waddr    (mem_waddr),
    .mem_wdata    (mem_wdata)
  );

  readout_engine #(
    .NUM_SLOTS (NUM_SLOTS),
    .SAMPLE_W  (SAMPLE_W),
    .IDX_W     (IDX_W)
  ) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_ok),
    .active     (state_q == ST_READOUT),
    .write_busy (mem_we),
    .stored     (stored),
    .mem_re     (mem_re),
    .mem_raddr  (mem_raddr),
    .mem_rdata  (mem_rdata),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample),
    .out_bunch  (out_bunch),
    .out_last   (out_last),
    .drained    (drained)
  );
endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 12,
  parameter int MISS_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pat_ready,
  input logic                armed,
  input logic                mem_we,
  input logic                mem_re,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_sample,
  input logic [IDX_W-1:0]    out_bunch,
  input logic                out_last,
  input logic                overflow,
  input logic [MISS_W-1:0]   missed_trains
);
  // R8: a stalled beat is held unchanged
  p_stream_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) &&
                                   $stable(out_bunch) && $stable(out_last)));

  // R10: reads and writes never overlap
  p_no_rw_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R9: missed-train count never decreases
  p_missed_monotonic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid || !out_valid |=> (missed_trains >= $past(missed_trains)));

  // R2: a loaded mask closes the mask input
  p_armed_closes_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !pat_ready);

  // R5: the cycle a drop is flagged carries no write
  p_overflow_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> !mem_we);

  // R7: beats appear only while draining, never while a mask is accepted
  p_stream_only_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!pat_ready && !armed));
endmodule

bind train_sample_sequencer tss_checker #(
  .SAMPLE_W (SAMPLE_W),
  .IDX_W    (IDX_W),
  .MISS_W   (MISS_W)
) u_tss_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pat_ready     (pat_ready),
  .armed         (armed),
  .mem_we        (mem_we),
  .mem_re        (mem_re),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_sample    (out_sample),
  .out_bunch     (out_bunch),
  .out_last      (out_last),
  .overflow      (overflow),
  .missed_trains (missed_trains)
);

// File: tb/tb_train_sample_sequencer.sv
`timescale 1ns/1ps
module tb_train_sample_sequencer;
  localparam int NB = 40;
  localparam int NS = 8;
  localparam int SW = 16;
  localparam int IW = 12;
  localparam int MSW = 3;
  localparam int AW = $clog2(NS);
  localparam int MW = IW + SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pat_valid = 1'b0, pat_bit = 1'b0;
  logic train_start = 1'b0, train_end = 1'b0, bunch_stb = 1'b0;
  logic [SW-1:0] sample_in = '0;
  logic out_ready = 1'b1;
  logic pat_ready, armed, mem_we, mem_re, out_valid, out_last, overflow;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [MW-1:0] mem_wdata, mem_rdata;
  logic [SW-1:0] out_sample;
  logic [IW-1:0] out_bunch;
  logic [MSW-1:0] missed_trains;

  always #5 clk = ~clk;

  train_sample_sequencer #(
    .NUM_BUNCHES(NB), .NUM_SLOTS(NS), .SAMPLE_W(SW), .IDX_W(IW), .MISS_W(MSW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_ready(pat_ready),
    .pat_bit(pat_bit), .train_start(train_start), .train_end(train_end),
    .bunch_stb(bunch_stb), .sample_in(sample_in), .armed(armed),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
    .out_bunch(out_bunch), .out_last(out_last), .overflow(overflow),
    .missed_trains(missed_trains)
  );

  // external sample memory, one cycle read latency
  logic [MW-1:0] mem [NS];
  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_raddr];
  end

  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   m_state = 0; // 0 wait,1 load,2 armed,3 capture,4 drain
  bit   m_mask [NB];
  int   m_pcnt = 0;
  int   m_idx = 0;
  int   m_stored = 0;
  bit   m_ovf = 0;
  int   m_missed = 0;
  bit   m_we = 0;
  int   m_waddr = 0;
  logic [MW-1:0] m_wdata = '0;
  logic [MW-1:0] m_q [$];
  bit   m_done = 0;
  int   n_pop = 0;
  bit   h_prev = 0;
  logic [SW-1:0] h_smp;
  logic [IW-1:0] h_tag;
  logic h_last;
  bit   rdy_mode = 0;
  int   cyc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_pcnt = 0; m_idx = 0; m_stored = 0; m_ovf = 0;
      m_missed = 0; m_we = 0; m_done = 0; h_prev = 0; m_q.delete();
    end else begin
      // R8: stalled beat must persist unchanged
      if (h_prev)
        chk(out_valid && out_sample == h_smp && out_bunch == h_tag && out_last == h_last,
            "R8 hold", {out_valid, out_bunch, out_sample}, {1'b1, h_tag, h_smp});
      h_prev = out_valid && !out_ready;
      h_smp = out_sample; h_tag = out_bunch; h_last = out_last;

      m_we = 0;
      if (train_start && (m_state == 0 || m_state == 1 || m_state == 4))
        if (m_missed < (1 << MSW) - 1) m_missed++;
      case (m_state)
        0, 1: if (pat_valid) begin
          m_mask[NB-1-m_pcnt] = pat_bit;
          m_pcnt++;
          if (m_pcnt == NB) begin m_pcnt = 0; m_state = 2; end else m_state = 1;
        end
        2: if (train_start) begin
          m_state = 3; m_idx = 0; m_stored = 0; m_ovf = 0; m_q.delete();
        end
        3: begin
          bit fin;
          fin = train_end;
          if (bunch_stb) begin
            if (m_mask[m_idx]) begin
              if (m_stored < NS) begin
                m_we = 1; m_waddr = m_stored;
                m_wdata = {IW'(m_idx), sample_in};
                m_q.push_back(m_wdata); m_stored++;
              end else m_ovf = 1;
            end
            if (m_idx == NB - 1) fin = 1; else m_idx++;
          end
          if (fin) begin m_state = 4; m_done = (m_q.size() == 0); end
        end
        4: begin
          if (m_done) begin m_state = 0; m_done = 0; end
          else if (out_valid && out_ready) begin
            logic [MW-1:0] e;
            e = m_q.pop_front();
            n_pop++;
            chk(out_bunch == e[MW-1:SW] && out_sample == e[SW-1:0],
                "R7 order", {out_bunch, out_sample}, e);
            chk(out_last == (m_q.size() == 0), "R7 last", out_last, m_q.size() == 0);
            if (m_q.size() == 0) m_done = 1;
          end
        end
        default: m_state = 0;
      endcase

      #2;
      chk(mem_we == m_we, "R4 write enable", mem_we, m_we);
      if (m_we)
        chk(mem_waddr == AW'(m_waddr) && mem_wdata == m_wdata, "R4 write addr/data",
            {mem_waddr, mem_wdata}, {AW'(m_waddr), m_wdata});
      chk(overflow == m_ovf, "R5 overflow", overflow, m_ovf);
      chk(missed_trains == MSW'(m_missed), "R9 missed", missed_trains, m_missed);
      chk(armed == (m_state == 2), "R3 armed", armed, m_state == 2);
      chk(pat_ready == (m_state <= 1), "R2 pat_ready", pat_ready, m_state <= 1);
      chk(!(mem_re && mem_we), "R10 overlap", {mem_re, mem_we}, 0);
    end
  end

  always @(negedge clk) begin
    cyc++;
    out_ready <= rdy_mode ? ((cyc % 3) != 0) : 1'b1;
  end

  // ---------------- stimulus ----------------
  int s_ctr = 0;

  task automatic send_mask(input logic [NB-1:0] p);
    for (int k = 0; k < NB; k++) begin
      @(negedge clk); pat_valid = 1'b1; pat_bit = p[NB-1-k];
    end
    @(negedge clk); pat_valid = 1'b0; pat_bit = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); train_start = 1'b1;
    @(negedge clk); train_start = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); train_end = 1'b1;
    @(negedge clk); train_end = 1'b0;
  endtask

  task automatic bunches(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bunch_stb = 1'b1; sample_in = SW'(16'h5a00 + s_ctr); s_ctr++;
      @(negedge clk); bunch_stb = 1'b0;
    end
  endtask

  task automatic wait_drained();
    @(negedge clk);
    while (!pat_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #3;
    chk(pat_ready && !armed && !out_valid && !mem_we && !mem_re && !overflow &&
        missed_trains == 0, "R1 reset",
        {pat_ready, armed, out_valid, mem_we, mem_re, overflow}, 6'b100000);

    // stray starts while waiting for a mask
    pulse_start(); pulse_start();
    chk(missed_trains == 2, "R9 idle starts", missed_trains, 2);

    // train A: sparse mask, ends at the final bunch position
    begin
      logic [NB-1:0] p = '0;
      p[0] = 1; p[3] = 1; p[4] = 1; p[17] = 1; p[38] = 1; p[39] = 1;
      send_mask(p);
    end
    @(negedge clk);
    chk(armed && !pat_ready, "R2 armed after mask", {armed, pat_ready}, 2'b10);
    n_pop = 0;
    pulse_start();
    chk(!armed, "R3 armed drops", armed, 0);
    bunches(NB);
    wait_drained();
    chk(n_pop == 6, "R7 count A", n_pop, 6);

    // train B: all ones, overflow, back-pressure, start during capture and drain
    send_mask('1);
    rdy_mode = 1; n_pop = 0;
    pulse_start();
    bunches(3);
    pulse_start();
    chk(missed_trains == 2, "R9 capture start ignored", missed_trains, 2);
    bunches(NB - 3);
    chk(overflow, "R5 overflow set", overflow, 1);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    pulse_start();
    wait_drained();
    chk(n_pop == NS, "R7 count B", n_pop, NS);
    chk(overflow, "R5 overflow held", overflow, 1);
    chk(missed_trains == 3, "R9 drain start", missed_trains, 3);
    rdy_mode = 0;

    // train C: empty mask, explicit end
    send_mask('0);
    n_pop = 0;
    pulse_start();
    chk(!overflow, "R5 overflow cleared", overflow, 0);
    bunches(5);
    pulse_end();
    wait_drained();
    chk(n_pop == 0, "R7 empty drain", n_pop, 0);

    // train D: end strobe early, later bunches must not store (R6)
    begin
      logic [NB-1:0] p = '0;
      p[2] = 1; p[5] = 1; p[9] = 1; p[10] = 1; p[11] = 1;
      send_mask(p);
    end
    n_pop = 0;
    pulse_start();
    bunches(10);
    pulse_end();
    bunches(2);
    wait_drained();
    chk(n_pop == 3, "R6 end stops capture", n_pop, 3);

    // saturation of the missed-train counter
    repeat (6) pulse_start();
    chk(missed_trains == 7, "R9 saturate", missed_trains, 7);

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule